// File: doc/BRIEF.md
# Flash Command Interface Controller

This block puts a command-driven front end on a byte-wide bulk-erase flash array. A host drives an asynchronous processor-style bus with active-low chip select, output enable and write strobe, an address and a byte of data. The block samples these pins on its own clock. A qualified write strobe stores the command byte in an internal latch that has no address of its own. The decoded command selects one of several modes: array reads, identification reads, a two-write bulk erase, a two-write byte program, or a return to array reads. Program and erase run on their own timing. A busy output is high for as long as one of them is running.

A digital programming-voltage enable guards every change to the array. While the enable is low, the command state machine stays in array-read mode and the part is a plain read-only memory. Bulk erase works in two passes. The first pass drives every byte to 00h, one address per clock. The second pass sets every byte to FFh, also one address per clock. Programming can only clear bits.

The state machine has seven states. `ST_READ` is array reads. `ST_IDENT` is identification reads. `ST_ERASE_ARM` waits for the erase confirmation. `ST_PROG_ARM` waits for the address and data byte. `ST_PROG_RUN` is the timed program. `ST_ERASE_FILL` is the pre-program pass. `ST_ERASE_WIPE` is the erase pass. The transitions are as follows:
- `ST_READ` and `ST_IDENT` go to `ST_READ` on 00h or FFh, to `ST_IDENT` on 80h or 90h, to `ST_ERASE_ARM` on 30h and to `ST_PROG_ARM` on 10h or 50h. Any other code leaves the state unchanged.
- `ST_ERASE_ARM` goes to `ST_ERASE_FILL` on 30h and to `ST_READ` on any other byte.
- `ST_PROG_ARM` goes to `ST_PROG_RUN` on the next write.
- `ST_PROG_RUN` goes to `ST_READ` when its cycle count runs out.
- `ST_ERASE_FILL` goes to `ST_ERASE_WIPE` after the last address.
- `ST_ERASE_WIPE` goes to `ST_READ` after the last address.
- Any state goes to `ST_READ` while the enable is low.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While `vpp_en` is low, bus writes change neither the mode nor the array. A program attempt leaves the target byte unchanged and `busy` low, and an identification command leaves reads returning array data.
- R2: When `vpp_en` returns high after being low, the block is in array-read mode, even if identification mode was active before the enable dropped.
- R3: A write is executed only if `ce_n` is low and `oe_n` is high at both the falling and the rising edge of `we_n`. A strobe made with `oe_n` low or `ce_n` high has no effect.
- R4: The address is taken at the falling edge of `we_n` and the data at the rising edge. An address change between the two edges does not move the target of a program.
- R5: Writing 00h or FFh selects array-read mode, so reads return the stored byte at `addr`. Two such writes in a row from identification mode restore array reads. Any code outside 00h, FFh, 80h, 90h, 30h, 10h and 50h leaves the mode unchanged.
- R6: Writing 80h or 90h selects identification mode. A read at address 0 then returns 01h, a read at address 1 returns AEh, and a read at any other address returns 00h.
- R7: A bulk erase starts only after two writes of 30h in a row. If the second byte is anything else, the block returns to array reads, the array is unchanged and `busy` stays low.
- R8: A write of 10h or 50h, followed by a write of the target address and byte, keeps `busy` high for exactly PROG_CYCLES clocks. After that the stored byte equals the old byte ANDed with the new one, and the block is in array-read mode.
- R9: A bulk erase keeps `busy` high for exactly 2 x 2^ADDR_W clocks: one pre-program pass and one erase pass, each covering every address once. Afterwards every location reads FFh.
- R10: Writes that complete while `busy` is high are ignored. An identification command given during an erase leaves the block in array-read mode once `busy` falls.
- R11: `data_oe` is high exactly when `ce_n` and `oe_n` are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; bus pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| vpp_en | input | 1 | Programming-voltage enable; low makes the part read-only |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Byte address |
| data_in | input | 8 | Write data from the host |
| data_out | output | 8 | Read data: the array byte or an identification code |
| data_oe | output | 1 | High when the block should drive the data bus |
| busy | output | 1 | High while a program or erase sequence runs |

## Verification
The bench builds the block with ADDR_W = 6 and PROG_CYCLES = 3. The 64-byte array makes a full bulk erase only 128 busy clocks long, so each location can be read back after every erase. It also lets random programs hit the same bytes often enough to exercise the AND rule. A short program time lets dozens of random program and read-back rounds fit in the run. The same settings leave room for writes that land in the middle of an erase.

// File: rtl/fci_pkg.sv
package fci_pkg;

    typedef enum logic [2:0] {
        ST_READ,
        ST_IDENT,
        ST_ERASE_ARM,
        ST_PROG_ARM,
        ST_PROG_RUN,
        ST_ERASE_FILL,
        ST_ERASE_WIPE
    } fci_state_e;

    localparam logic [7:0] CODE_READ_A  = 8'h00;
    localparam logic [7:0] CODE_READ_B  = 8'hFF;
    localparam logic [7:0] CODE_IDENT_A = 8'h80;
    localparam logic [7:0] CODE_IDENT_B = 8'h90;
    localparam logic [7:0] CODE_ERASE   = 8'h30;
    localparam logic [7:0] CODE_PROG_A  = 8'h10;
    localparam logic [7:0] CODE_PROG_B  = 8'h50;

    localparam logic [7:0] IDENT_MAKER  = 8'h01;
    localparam logic [7:0] IDENT_DEVICE = 8'hAE;

endpackage

// File: rtl/fci_bus_capture.sv
module fci_bus_capture #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic we_q;
    logic armed;
    logic qual;

    assign qual = ~ce_n & oe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b1;
            armed   <= 1'b0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            we_q   <= we_n;
            wr_stb <= 1'b0;
            // falling strobe edge: take the address
            if (we_q && !we_n) begin
                armed <= qual;
                if (qual) wr_addr <= addr;
            end
            // rising strobe edge: take the data and fire
            if (!we_q && we_n) begin
                armed <= 1'b0;
                if (armed && qual) begin
                    wr_stb  <= 1'b1;
                    wr_data <= din;
                end
            end
        end
    end
endmodule

// File: rtl/fci_array.sv
module fci_array #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/fci_ctrl.sv
module fci_ctrl
    import fci_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vpp_en,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] old_data,
    output fci_state_e        state,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] prog_addr
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(PROG_CYCLES - 1);
    localparam logic [ADDR_W-1:0] IDX_LAST = '1;

    fci_state_e        state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [ADDR_W-1:0] idx, idx_n;
    logic [ADDR_W-1:0] paddr_n;
    logic [DATA_W-1:0] pdata, pdata_n;

    // next-state logic
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        idx_n   = idx;
        paddr_n = prog_addr;
        pdata_n = pdata;
        if (!vpp_en) begin
            state_n = ST_READ;
        end else begin
            unique case (state)
                ST_READ, ST_IDENT: begin
                    if (wr_stb) begin
                        if (wr_data == CODE_READ_A || wr_data == CODE_READ_B)
                            state_n = ST_READ;
                        else if (wr_data == CODE_IDENT_A || wr_data == CODE_IDENT_B)
                            state_n = ST_IDENT;
                        else if (wr_data == CODE_ERASE)
                            state_n = ST_ERASE_ARM;
                        else if (wr_data == CODE_PROG_A || wr_data == CODE_PROG_B)
                            state_n = ST_PROG_ARM;
                    end
                end
                ST_ERASE_ARM: begin
                    if (wr_stb) begin
                        idx_n   = '0;
                        state_n = (wr_data == CODE_ERASE) ? ST_ERASE_FILL : ST_READ;
                    end
                end
                ST_PROG_ARM: begin
                    if (wr_stb) begin
                        paddr_n = wr_addr;
                        pdata_n = wr_data;
                        cnt_n   = '0;
                        state_n = ST_PROG_RUN;
                    end
                end
                ST_PROG_RUN: begin
                    if (cnt == CNT_LAST) state_n = ST_READ;
                    else                 cnt_n   = cnt + 1'b1;
                end
                ST_ERASE_FILL: begin
                    idx_n = idx + 1'b1;
                    if (idx == IDX_LAST) state_n = ST_ERASE_WIPE;
                end
                ST_ERASE_WIPE: begin
                    idx_n = idx + 1'b1;
                    if (idx == IDX_LAST) state_n = ST_READ;
                end
                default: state_n = ST_READ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_READ;
            cnt       <= '0;
            idx       <= '0;
            prog_addr <= '0;
            pdata     <= '0;
        end else begin
            state     <= state_n;
            cnt       <= cnt_n;
            idx       <= idx_n;
            prog_addr <= paddr_n;
            pdata     <= pdata_n;
        end
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = idx;
        mem_wdata = '1;
        unique case (state)
            ST_PROG_RUN: begin
                busy      = 1'b1;
                mem_we    = vpp_en && (cnt == CNT_LAST);
                mem_addr  = prog_addr;
                mem_wdata = old_data & pdata;
            end
            ST_ERASE_FILL: begin
                busy      = 1'b1;
                mem_we    = vpp_en;
                mem_wdata = '0;
            end
            ST_ERASE_WIPE: begin
                busy      = 1'b1;
                mem_we    = vpp_en;
                mem_wdata = '1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fci_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PROG_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vpp_en,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data_in,
    output logic [7:0]        data_out,
    output logic              data_oe,
    output logic              busy
);
    localparam int DATA_W = 8;

    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    fci_state_e        state;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [ADDR_W-1:0] prog_addr;
    logic [DATA_W-1:0] rd_host;
    logic [DATA_W-1:0] rd_prog;

    fci_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) cap_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(data_in),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    fci_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .vpp_en(vpp_en),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .old_data(rd_prog), .state(state), .busy(busy),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .prog_addr(prog_addr)
    );

    fci_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
        .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
        .raddr_a(addr), .rdata_a(rd_host),
        .raddr_b(prog_addr), .rdata_b(rd_prog)
    );

    always_comb begin
        if (state == ST_IDENT) begin
            if (addr == '0)                 data_out = IDENT_MAKER;
            else if (addr == ADDR_W'(1))    data_out = IDENT_DEVICE;
            else                            data_out = 8'h00;
        end else begin
            data_out = rd_host;
        end
    end

    assign data_oe = ~ce_n & ~oe_n;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
    import fci_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       vpp_en,
    input logic       ce_n,
    input logic       oe_n,
    input logic       we_n,
    input logic       wr_stb,
    input logic       busy,
    input fci_state_e state
);
    // R1, R2: enable low parks the machine in array reads
    p_locked_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_en |=> state == ST_READ);

    // R3: a strobe only fires after a qualified rising edge
    p_qualified_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(!ce_n && oe_n && we_n));

    // R7: the arm state leads only to erase or back to reads
    p_erase_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ERASE_ARM |=> state inside {ST_ERASE_ARM, ST_ERASE_FILL, ST_READ});

    // R10: a busy sequence only starts from a write
    p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_stb));

    // R10: writes during busy cannot steer the mode
    p_busy_ends_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || state == ST_READ));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .vpp_en(vpp_en), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .wr_stb(wr_stb), .busy(busy), .state(state)
);

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int PCYC  = 3;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          vpp_en;
    logic          ce_n, oe_n, we_n;
    logic [AW-1:0] addr;
    logic [7:0]    data_in;
    logic [7:0]    data_out;
    logic          data_oe;
    logic          busy;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(AW), .PROG_CYCLES(PCYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .vpp_en(vpp_en), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .addr(addr), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .busy(busy)
    );

    function automatic logic [7:0] ident_value(input logic [AW-1:0] a);
        if (a == 0) return 8'h01;
        if (a == 1) return 8'hAE;
        return 8'h00;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write_full(input logic [AW-1:0] a, input logic [AW-1:0] late_a,
                                  input logic [7:0] d, input bit ce_v, input bit oe_v);
        @(negedge clk); addr = a; ce_n = ce_v; oe_n = oe_v; we_n = 1'b1;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk); addr = late_a; data_in = d;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        bus_write_full(a, a, d, 1'b0, 1'b1);
    endtask

    task automatic run_busy(output int n);
        n = 0;
        for (int i = 0; i < 4 * DEPTH + 50; i++) begin
            @(negedge clk);
            if (busy) n++;
            else if (n > 0 || i > 3) break;
        end
    endtask

    task automatic read_chk(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        chk(data_oe === 1'b1, "R11", int'(data_oe), 1);
        chk(data_out === exp, req, int'(data_out), int'(exp));
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int seed;
        logic [AW-1:0] a, b;
        logic [7:0] d;
        seed = int'($urandom(32'd2024));
        rst_n = 1'b0; vpp_en = 1'b1; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        addr = '0; data_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0, "reset busy", int'(busy), 0);
        chk(data_oe === 1'b0, "R11 reset", int'(data_oe), 0);

        // R9: full bulk erase
        bus_write(0, 8'h30); bus_write(0, 8'h30);
        run_busy(n);
        chk(n == 2 * DEPTH, "R9 busy length", n, 2 * DEPTH);
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        for (int i = 0; i < DEPTH; i++) read_chk(AW'(i), 8'hFF, "R9 erased");

        // R6: identification reads
        bus_write(0, 8'h90);
        for (int i = 0; i < 4; i++) read_chk(AW'(i), ident_value(AW'(i)), "R6 ident 90h");
        bus_write(0, 8'h00);
        bus_write(0, 8'h80);
        read_chk(1, 8'hAE, "R6 ident 80h");
        read_chk(AW'(DEPTH - 1), 8'h00, "R6 ident other");

        // R5: two FFh writes restore array reads; unknown code ignored
        bus_write(0, 8'hFF); bus_write(0, 8'hFF);
        read_chk(0, model[0], "R5 reset to read");
        bus_write(0, 8'h42);
        run_busy(n);
        chk(n == 0, "R5 unknown no busy", n, 0);
        read_chk(1, model[1], "R5 unknown ignored");
        bus_write(0, 8'h90); bus_write(0, 8'h42);
        read_chk(0, 8'h01, "R5 unknown keeps ident");
        bus_write(0, 8'h00);

        // R8: directed then random programs
        bus_write(0, 8'h10); bus_write(0, 8'h5A);
        run_busy(n);
        chk(n == PCYC, "R8 busy length", n, PCYC);
        model[0] = model[0] & 8'h5A;
        read_chk(0, model[0], "R8 program");
        for (int k = 0; k < 40; k++) begin
            a = AW'($urandom);
            d = 8'($urandom);
            bus_write(0, ($urandom % 2) ? 8'h10 : 8'h50);
            bus_write(a, d);
            run_busy(n);
            chk(n == PCYC, "R8 busy length rnd", n, PCYC);
            model[a] = model[a] & d;
            read_chk(a, model[a], "R8 AND rule");
            b = AW'($urandom);
            read_chk(b, model[b], "R8 other byte");
        end

        // R4: address taken at the falling edge
        bus_write(0, 8'h50);
        bus_write_full(AW'(10), AW'(20), 8'h33, 1'b0, 1'b1);
        run_busy(n);
        model[10] = model[10] & 8'h33;
        read_chk(10, model[10], "R4 fall address");
        read_chk(20, model[20], "R4 late address untouched");

        // R3: unqualified strobes
        bus_write_full(0, 0, 8'h90, 1'b0, 1'b0);
        read_chk(0, model[0], "R3 oe low ignored");
        bus_write_full(0, 0, 8'h90, 1'b1, 1'b1);
        read_chk(0, model[0], "R3 ce high ignored");
        bus_write_full(0, 0, 8'h10, 1'b0, 1'b0);
        bus_write(AW'(5), 8'h00);
        run_busy(n);
        chk(n == 0, "R3 no program", n, 0);
        read_chk(5, model[5], "R3 byte intact");

        // R1: enable low locks the block
        vpp_en = 1'b0;
        bus_write(0, 8'h10); bus_write(AW'(3), 8'h00);
        run_busy(n);
        chk(n == 0, "R1 no busy", n, 0);
        read_chk(3, model[3], "R1 array intact");
        bus_write(0, 8'h90);
        read_chk(0, model[0], "R1 no ident");
        vpp_en = 1'b1;

        // R2: enable drop leaves identification mode
        bus_write(0, 8'h90);
        read_chk(1, 8'hAE, "R2 ident before drop");
        @(negedge clk); vpp_en = 1'b0;
        repeat (2) @(negedge clk);
        vpp_en = 1'b1;
        read_chk(1, model[1], "R2 read after rise");

        // R11: output enable gating
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        chk(data_oe === 1'b0, "R11 oe high", int'(data_oe), 0);
        ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk);
        chk(data_oe === 1'b0, "R11 ce high", int'(data_oe), 0);
        oe_n = 1'b1;

        // R7: aborted erase
        bus_write(0, 8'h30); bus_write(0, 8'h00);
        run_busy(n);
        chk(n == 0, "R7 abort no busy", n, 0);
        read_chk(0, model[0], "R7 abort array intact");
        bus_write(0, 8'h30); bus_write(0, 8'h90);
        read_chk(0, model[0], "R7 abort to read");

        // R10: identification command during erase is dropped
        bus_write(0, 8'h30); bus_write(0, 8'h30);
        bus_write(0, 8'h90);
        run_busy(n);
        read_chk(0, 8'hFF, "R10 write during busy ignored");
        for (int i = 0; i < DEPTH; i++) read_chk(AW'(i), 8'hFF, "R9 second erase");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule